// File: doc/BRIEF.md
# Speculative Integer Register File With Committed Shadow and Flush Restore

This block holds the integer register state of an out-of-order core in two copies. The speculative copy tracks the newest in-flight results, and the committed copy tracks retired results. Instructions still in flight read their operands from the speculative copy and write their results to it through one write port. Retiring instructions update the committed copy through a separate commit port. A small bank of scratch registers for microcode sits beside both copies.

When a branch turns out mispredicted, or an exception is taken, the core raises `flush`. At that clock edge every speculative register takes the value of its committed counterpart. The speculative state then matches the retired state again, and execution can restart from the correct path.

All read ports are combinational and take a 6-bit index into one flat map. Indices 0 to 15 select the speculative copy, 16 to 31 the committed copy, and 32 to 39 the scratch bank.

Top module: `spec_regfile_rb`

## Requirements
- R1: After reset every register in all three sets reads as zero.
- R2: Read index map (6 bits): 0..15 return the speculative register of the same number, 16..31 return committed register (index-16), 32..39 return scratch register (index-32), and 40..63 return zero.
- R3: A speculative write (`sw_en`) to index 0..15, with `flush` low, updates that speculative register at the next rising edge and leaves the committed registers unchanged.
- R4: While a speculative write to index 0..15 is presented with `flush` low, a read port addressing the same index returns `sw_data` in that same cycle.
- R5: A commit write (`cm_en`, 4-bit `cm_idx`) updates committed register `cm_idx` at the next rising edge and leaves the speculative registers unchanged.
- R6: When `flush` is high at a rising edge, every speculative register afterwards equals its committed counterpart.
- R7: A commit write in the same cycle as `flush` lands in the committed register, and its value is also the value restored into the matching speculative register.
- R8: A speculative write to index 0..15 in a `flush` cycle is discarded and is not bypassed: a read of that index in the same cycle returns the stored speculative value.
- R9: Scratch registers are written through the speculative port at indices 32..39, including in a `flush` cycle, and are never changed by `flush` itself. Scratch reads return the stored value, with no bypass.
- R10: Speculative writes to indices 16..31 or 40..63 change no register.
- R11: The three read ports decode their indices independently and may address any mix of sets in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_idx | input | 3x6 | Read indices, one per port |
| rd_data | output | 3x64 | Read data, one per port, combinational |
| sw_en | input | 1 | Speculative write enable |
| sw_idx | input | 6 | Speculative write index |
| sw_data | input | 64 | Speculative write data |
| cm_en | input | 1 | Commit write enable |
| cm_idx | input | 4 | Committed register number |
| cm_data | input | 64 | Commit write data |
| flush | input | 1 | Restore speculative copy from committed copy |

## Verification
The speculative and committed copies are first loaded with different patterns, so any read routed to the wrong set shows up as a data mismatch. Flushes are then applied alone, together with a commit, and together with a speculative write to the same or another register. These cases separate a correct restore from a stale restore, a missed commit merge, or a speculative write that leaked through. Scratch writes made before and during a flush show whether the scratch bank is wrongly tied to the restore. Same-cycle read-after-write is tried with and without `flush`, which separates the bypass path from the stored value.

// File: rtl/spec_regfile_rb.sv
module spec_regfile_rb #(
  parameter int XLEN  = 64,
  parameter int NARCH = 16,
  parameter int NSCR  = 8,
  parameter int NRD   = 3,
  localparam int TOT  = 2*NARCH + NSCR,
  localparam int IW   = $clog2(TOT),
  localparam int AW   = $clog2(NARCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][IW-1:0]   rd_idx,
  output logic [NRD-1:0][XLEN-1:0] rd_data,
  input  logic                     sw_en,
  input  logic [IW-1:0]            sw_idx,
  input  logic [XLEN-1:0]          sw_data,
  input  logic                     cm_en,
  input  logic [AW-1:0]            cm_idx,
  input  logic [XLEN-1:0]          cm_data,
  input  logic                     flush
);
  localparam int SW = (NSCR > 1) ? $clog2(NSCR) : 1;

  logic [XLEN-1:0] fut_q  [NARCH];
  logic [XLEN-1:0] arch_q [NARCH];
  logic [XLEN-1:0] scr_q  [NSCR];

  logic fut_wr, scr_wr;
  assign fut_wr = sw_en && !flush && (sw_idx < IW'(NARCH));
  assign scr_wr = sw_en && (sw_idx >= IW'(2*NARCH)) && (sw_idx < IW'(TOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) arch_q[i] <= '0;
    end else if (cm_en) begin
      arch_q[cm_idx] <= cm_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) fut_q[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < NARCH; i++)
        fut_q[i] <= (cm_en && cm_idx == AW'(i)) ? cm_data : arch_q[i];
    end else if (fut_wr) begin
      fut_q[sw_idx[AW-1:0]] <= sw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSCR; i++) scr_q[i] <= '0;
    end else if (scr_wr) begin
      scr_q[SW'(sw_idx - IW'(2*NARCH))] <= sw_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IW-1:0]   ri;
    logic [XLEN-1:0] rv;
    assign ri = rd_idx[p];
    always_comb begin
      rv = '0;
      if (ri < IW'(NARCH))
        rv = (fut_wr && sw_idx == ri) ? sw_data : fut_q[ri[AW-1:0]];
      else if (ri < IW'(2*NARCH))
        rv = arch_q[ri[AW-1:0]];
      else if (ri < IW'(TOT))
        rv = scr_q[SW'(ri - IW'(2*NARCH))];
    end
    assign rd_data[p] = rv;

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fut_wr && ri == sw_idx) |=> fut_q[$past(sw_idx[AW-1:0])] == $past(rv));
  end

  for (genvar k = 0; k < NARCH; k++) begin : g_chk_arch
    // R6
    flush_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> fut_q[k] == arch_q[k]);
    // R5
    arch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cm_en && cm_idx == AW'(k)) |=> $stable(arch_q[k]));
    // R3
    fut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !(sw_en && sw_idx == IW'(k))) |=> $stable(fut_q[k]));
  end

  for (genvar j = 0; j < NSCR; j++) begin : g_chk_scr
    // R9
    scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_en && sw_idx == IW'(2*NARCH + j)) |=> $stable(scr_q[j]));
  end
endmodule

// File: tb/test_spec_regfile_rb.sv
`timescale 1ns/1ps
module test_spec_regfile_rb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][5:0]  rd_idx;
  logic [2:0][63:0] rd_data;
  logic sw_en = 1'b0, cm_en = 1'b0, flush = 1'b0;
  logic [5:0]  sw_idx = '0;
  logic [63:0] sw_data = '0, cm_data = '0;
  logic [3:0]  cm_idx = '0;

  always #10 clk = ~clk;

  spec_regfile_rb i_spec_regfile_rb (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_data(sw_data),
    .cm_en(cm_en), .cm_idx(cm_idx), .cm_data(cm_data), .flush(flush));

  logic [63:0] mfut [16];
  logic [63:0] march[16];
  logic [63:0] mscr [8];

  logic [63:0] exp_q[$];
  int          port_q[$];
  string       tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [63:0] pat(int k, int salt);
    return {16'(salt), 16'(k), 32'h5EED_0000 ^ 32'(k * 977 + salt * 31)};
  endfunction

  function automatic logic [63:0] model_rd(logic [5:0] ri);
    if (ri < 16) return (sw_en && !flush && sw_idx == ri) ? sw_data : mfut[ri[3:0]];
    if (ri < 32) return march[ri[3:0]];
    if (ri < 40) return mscr[ri[2:0]];
    return 64'd0;
  endfunction

  task automatic step(input logic [5:0] r0, r1, r2,
                      input logic we, input logic [5:0] wi, input logic [63:0] wd,
                      input logic ce, input logic [3:0] ci, input logic [63:0] cd,
                      input logic fl, input string tag);
    @(negedge clk);
    rd_idx[0] = r0; rd_idx[1] = r1; rd_idx[2] = r2;
    sw_en = we; sw_idx = wi; sw_data = wd;
    cm_en = ce; cm_idx = ci; cm_data = cd; flush = fl;
    for (int p = 0; p < 3; p++) begin
      exp_q.push_back(model_rd(rd_idx[p]));
      port_q.push_back(p);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    if (ce) march[ci] = cd;
    if (fl) for (int i = 0; i < 16; i++) mfut[i] = march[i];
    else if (we && wi < 16) mfut[wi[3:0]] = wd;
    if (we && wi >= 32 && wi < 40) mscr[wi[2:0]] = wd;
  endtask

  task automatic rd3(input logic [5:0] r0, r1, r2, input string tag);
    step(r0, r1, r2, 1'b0, 6'd0, 64'd0, 1'b0, 4'd0, 64'd0, 1'b0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      while (exp_q.size() > 0) begin
        logic [63:0] e;
        int p;
        string t;
        e = exp_q.pop_front(); p = port_q.pop_front(); t = tag_q.pop_front();
        n_cmp++;
        if (rd_data[p] !== e) begin
          n_bad++;
          $display("FAIL %s port %0d: got %h expected %h", t, p, rd_data[p], e);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    rd_idx = '0;
    for (int i = 0; i < 16; i++) begin mfut[i] = '0; march[i] = '0; end
    for (int i = 0; i < 8; i++) mscr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset contents across all sets
    rd3(6'd0, 6'd16, 6'd32, "R1");
    rd3(6'd15, 6'd31, 6'd39, "R1");

    // R3 fill speculative copy, committed copy must stay zero
    for (int k = 0; k < 16; k++)
      step(6'(k), 6'(16 + k), 6'd40, 1'b1, 6'(k), pat(k, 1), 1'b0, 4'd0, 64'd0, 1'b0, "R3");
    for (int k = 0; k < 16; k++) rd3(6'(k), 6'(16 + k), 6'(15 - k), "R3");

    // R5 fill committed copy, speculative copy must keep its values
    for (int k = 0; k < 16; k++)
      step(6'(k), 6'(16 + k), 6'd0, 1'b0, 6'd0, 64'd0, 1'b1, 4'(k), pat(k, 2), 1'b0, "R5");
    for (int k = 0; k < 16; k++) rd3(6'(k), 6'(16 + k), 6'(31 - k), "R5");

    // R4 bypass of same-cycle write on several ports
    step(6'd5, 6'd5, 6'd21, 1'b1, 6'd5, pat(5, 3), 1'b0, 4'd0, 64'd0, 1'b0, "R4");
    step(6'd9, 6'd2, 6'd9, 1'b1, 6'd9, pat(9, 3), 1'b0, 4'd0, 64'd0, 1'b0, "R4");
    rd3(6'd5, 6'd9, 6'd25, "R4");

    // R9 scratch fill
    for (int j = 0; j < 8; j++)
      step(6'(32 + j), 6'd0, 6'd0, 1'b1, 6'(32 + j), pat(j, 4), 1'b0, 4'd0, 64'd0, 1'b0, "R9");
    for (int j = 0; j < 8; j++) rd3(6'(32 + j), 6'(39 - j), 6'(j), "R9");

    // R10 ignored write targets
    step(6'd20, 6'd45, 6'd4, 1'b1, 6'd20, 64'hDEAD_BEEF_0000_0001, 1'b0, 4'd0, 64'd0, 1'b0, "R10");
    step(6'd20, 6'd45, 6'd63, 1'b1, 6'd45, 64'hDEAD_BEEF_0000_0002, 1'b0, 4'd0, 64'd0, 1'b0, "R10");
    rd3(6'd20, 6'd45, 6'd4, "R10");
    for (int k = 0; k < 16; k++) rd3(6'(k), 6'(16 + k), 6'(32 + (k % 8)), "R10");

    // R2 unmapped indices read zero
    for (int k = 40; k < 64; k += 3) rd3(6'(k), 6'(k + 1), 6'(k + 2 > 63 ? 63 : k + 2), "R2");

    // R8 flush with a same-register write and a commit on another register; R7 commit merge
    step(6'd7, 6'd3, 6'd19, 1'b1, 6'd7, 64'hBAD0_BAD0_BAD0_0007, 1'b1, 4'd3, pat(3, 7), 1'b1, "R8");
    // R6 full restore check, R7 merged commit at 3
    for (int k = 0; k < 16; k++) rd3(6'(k), 6'(16 + k), 6'(32 + (k % 8)), "R6");
    rd3(6'd3, 6'd19, 6'd7, "R7");

    // new speculative state, then flush with scratch write and commit to a written register
    for (int k = 0; k < 16; k += 2)
      step(6'(k), 6'd0, 6'd0, 1'b1, 6'(k), pat(k, 8), 1'b0, 4'd0, 64'd0, 1'b0, "R3");
    step(6'd34, 6'd10, 6'd26, 1'b1, 6'd34, pat(2, 9), 1'b1, 4'd10, pat(10, 9), 1'b1, "R9");
    for (int k = 0; k < 16; k++) rd3(6'(k), 6'(16 + k), 6'(32 + (k % 8)), "R6");
    rd3(6'd10, 6'd26, 6'd34, "R7");

    // R11 mixed-set reads across ports
    for (int k = 0; k < 16; k++) rd3(6'(32 + (k % 8)), 6'(k), 6'(16 + ((k * 5) % 16)), "R11");

    // R1 reset again clears everything
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin mfut[i] = '0; march[i] = '0; end
    for (int i = 0; i < 8; i++) mscr[i] = '0;
    @(negedge clk) rst_n = 1'b1;
    rd3(6'd3, 6'd19, 6'd34, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule